// File: doc/BRIEF.md
# Nibble Adder with Decimal Mode and Register Pointer

This block is the 4-bit add unit of a small microcontroller datapath. Each accepted request carries two nibbles: one read from a general-register location and one read directly from data memory. The unit adds them and emits a writeback beat that stores the sum into the general-register location. The sum is either plain binary or decimal-corrected (BCD). A carry flag and a zero flag are updated at the same clock edge.

The general-register location comes from a register pointer held inside the block. The pointer is two 4-bit registers. The high register gives the bank. The upper three bits of the low register give the row within that bank. The lowest bit of the low register is not part of the row: it is the decimal-mode switch. The general-register address is the row in the upper bits followed by the 4-bit offset carried by the request. A compare-mode input changes how the zero flag reacts to a zero result.

Requests use a valid/ready pair, and so does the writeback beat. The writeback holds one entry. A new request is accepted only when that entry is empty or is being consumed in the same cycle. While the writeback is stalled, its data, address and the flags stay frozen.

Top module: `nibadd_top`

## Requirements
- R1: In binary mode (pointer low bit 0 = 0), an accepted request gives wb_data = (gr + mem) mod 16 and carry_flag = bit 4 of the 5-bit sum, both visible after the accepting edge.
- R2: In decimal mode (pointer low bit 0 = 1), if the 5-bit binary sum exceeds 9, then 6 is added, wb_data is the low nibble of that corrected value and carry_flag is 1. Otherwise wb_data is the sum and carry_flag is 0.
- R3: When an accepted result is zero and cmp_mode is 0, zero_flag becomes 1.
- R4: When an accepted result is zero and cmp_mode is 1, zero_flag keeps its previous value.
- R5: When an accepted result is nonzero, zero_flag becomes 0 for either value of cmp_mode.
- R6: gr_bank and wb_bank equal the pointer high register. gr_addr and wb_addr equal {pointer low bits 3:1, req_ofs}. For example, low register 4 with offset 3 gives address 0x23.
- R7: ptr_hi_we loads ptr_wdata into the high register, and ptr_lo_we loads it into the low register, at the clock edge. A request accepted at that same edge still uses the old pointer.
- R8: req_ready = !wb_valid || wb_ready. While wb_valid=1 and wb_ready=0, wb_data, wb_addr, wb_bank, carry_flag and zero_flag hold, and no request is accepted.
- R9: Synchronous reset clears both pointer registers, carry_flag, zero_flag and wb_valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ptr_hi_we | input | 1 | Load the pointer bank register |
| ptr_lo_we | input | 1 | Load the pointer row/mode register |
| ptr_wdata | input | 4 | Value for pointer loads |
| req_valid | input | 1 | Add request present |
| req_ready | output | 1 | Request accepted this cycle when valid |
| req_gr | input | 4 | General-register operand nibble |
| req_mem | input | 4 | Data-memory operand nibble |
| req_ofs | input | 4 | General-register offset within the row |
| cmp_mode | input | 1 | Compare mode: a zero result leaves zero_flag unchanged |
| wb_valid | output | 1 | Writeback beat present |
| wb_ready | input | 1 | Writeback consumer ready |
| wb_data | output | 4 | Sum to store |
| wb_bank | output | 4 | Bank of the writeback location |
| wb_addr | output | 7 | Writeback address {row, offset} |
| carry_flag | output | 1 | Carry flag |
| zero_flag | output | 1 | Zero flag |
| gr_bank | output | 4 | Current pointer bank |
| gr_addr | output | 7 | General-register address for the current request |
| dec_mode | output | 1 | Current decimal-mode bit |

## Verification
The hardest case to reach is the compare-mode hold of the zero flag. It is only visible if the flag already holds a value that a zero result would otherwise overwrite. The stimulus therefore first forces zero_flag to 1 with a wrapping binary add (8+8) and to 0 with a nonzero add. Only then does it issue zero-result adds with cmp_mode set, including 15+1, which is zero only after the wrap. The stalled-writeback case is reached by lowering wb_ready and then holding a second request valid for several cycles.

// File: rtl/nibadd_pkg.sv
package nibadd_pkg;
  typedef enum logic {MODE_BIN = 1'b0, MODE_DEC = 1'b1} add_mode_e;
  localparam int DEC_LIMIT = 9;
  localparam int DEC_BASE  = 10;
endpackage

// File: rtl/gr_pointer.sv
module gr_pointer #(
  parameter int PTR_W = 4,
  localparam int ROW_W = PTR_W - 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             hi_we,
  input  logic             lo_we,
  input  logic [PTR_W-1:0] wdata,
  output logic [PTR_W-1:0] bank,
  output logic [ROW_W-1:0] row,
  output nibadd_pkg::add_mode_e mode
);
  logic [PTR_W-1:0] hi_q, lo_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_q <= '0;
      lo_q <= '0;
    end else begin
      if (hi_we) hi_q <= wdata;
      if (lo_we) lo_q <= wdata;
    end
  end

  assign bank = hi_q;
  assign row  = lo_q[PTR_W-1:1];
  assign mode = nibadd_pkg::add_mode_e'(lo_q[0]);
endmodule

// File: rtl/nib_adder.sv
module nib_adder #(
  parameter int W      = 4,
  parameter bit DEC_EN = 1'b1
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  nibadd_pkg::add_mode_e mode,
  output logic [W-1:0] res,
  output logic         cout
);
  localparam int SW = W + 1;
  localparam logic [SW-1:0] LIMIT = SW'(nibadd_pkg::DEC_LIMIT);
  localparam logic [SW-1:0] CORR  = SW'((1 << W) - nibadd_pkg::DEC_BASE);

  logic [SW-1:0] raw;
  assign raw = {1'b0, a} + {1'b0, b};

  generate
    if (DEC_EN) begin : g_dec
      logic          over;
      logic [SW-1:0] fixed;
      assign over  = raw > LIMIT;
      assign fixed = raw + CORR;
      always_comb begin
        if (mode == nibadd_pkg::MODE_DEC) begin
          res  = over ? fixed[W-1:0] : raw[W-1:0];
          cout = over;
        end else begin
          res  = raw[W-1:0];
          cout = raw[W];
        end
      end
    end else begin : g_bin
      logic unused_mode;
      assign unused_mode = mode;
      assign res  = raw[W-1:0];
      assign cout = raw[W];
    end
  endgenerate
endmodule

// File: rtl/zc_flags.sv
module zc_flags #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         upd,
  input  logic [W-1:0] res,
  input  logic         cin,
  input  logic         cmp,
  output logic         carry,
  output logic         zero
);
  logic res_zero;
  assign res_zero = (res == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      carry <= 1'b0;
      zero  <= 1'b0;
    end else if (upd) begin
      carry <= cin;
      if (!res_zero)  zero <= 1'b0;
      else if (!cmp)  zero <= 1'b1;
    end
  end
endmodule

// File: rtl/nibadd_top.sv
module nibadd_top #(
  parameter int NIB_W  = 4,
  parameter int PTR_W  = 4,
  parameter int OFS_W  = 4,
  parameter bit DEC_EN = 1'b1,
  localparam int ROW_W  = PTR_W - 1,
  localparam int ADDR_W = ROW_W + OFS_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ptr_hi_we,
  input  logic              ptr_lo_we,
  input  logic [PTR_W-1:0]  ptr_wdata,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [NIB_W-1:0]  req_gr,
  input  logic [NIB_W-1:0]  req_mem,
  input  logic [OFS_W-1:0]  req_ofs,
  input  logic              cmp_mode,
  output logic              wb_valid,
  input  logic              wb_ready,
  output logic [NIB_W-1:0]  wb_data,
  output logic [PTR_W-1:0]  wb_bank,
  output logic [ADDR_W-1:0] wb_addr,
  output logic              carry_flag,
  output logic              zero_flag,
  output logic [PTR_W-1:0]  gr_bank,
  output logic [ADDR_W-1:0] gr_addr,
  output logic              dec_mode
);
  logic [ROW_W-1:0]      row;
  nibadd_pkg::add_mode_e mode;
  logic [NIB_W-1:0]      sum;
  logic                  cout;
  logic                  fire;

  gr_pointer #(.PTR_W(PTR_W)) u_ptr (
    .clk(clk), .rst(rst), .hi_we(ptr_hi_we), .lo_we(ptr_lo_we),
    .wdata(ptr_wdata), .bank(gr_bank), .row(row), .mode(mode)
  );

  nib_adder #(.W(NIB_W), .DEC_EN(DEC_EN)) u_add (
    .a(req_gr), .b(req_mem), .mode(mode), .res(sum), .cout(cout)
  );

  assign req_ready = !wb_valid || wb_ready;
  assign fire      = req_valid && req_ready;
  assign gr_addr   = {row, req_ofs};
  assign dec_mode  = (mode == nibadd_pkg::MODE_DEC);

  zc_flags #(.W(NIB_W)) u_flags (
    .clk(clk), .rst(rst), .upd(fire), .res(sum), .cin(cout),
    .cmp(cmp_mode), .carry(carry_flag), .zero(zero_flag)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      wb_valid <= 1'b0;
      wb_data  <= '0;
      wb_bank  <= '0;
      wb_addr  <= '0;
    end else if (fire) begin
      wb_valid <= 1'b1;
      wb_data  <= sum;
      wb_bank  <= gr_bank;
      wb_addr  <= gr_addr;
    end else if (wb_ready) begin
      wb_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/nibadd_chk.sv
module nibadd_chk #(
  parameter int NIB_W  = 4,
  parameter int PTR_W  = 4,
  parameter int ADDR_W = 7
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              req_ready,
  input logic [NIB_W-1:0]  req_gr,
  input logic [NIB_W-1:0]  req_mem,
  input logic              cmp_mode,
  input logic              wb_valid,
  input logic              wb_ready,
  input logic [NIB_W-1:0]  wb_data,
  input logic [PTR_W-1:0]  wb_bank,
  input logic [ADDR_W-1:0] wb_addr,
  input logic              carry_flag,
  input logic              zero_flag,
  input logic              dec_mode
);
  logic fire;
  logic [NIB_W:0] wide;
  assign fire = req_valid && req_ready;
  assign wide = {1'b0, req_gr} + {1'b0, req_mem};

  // R1
  a_r1_bin_sum: assert property (@(posedge clk) disable iff (rst)
    fire && !dec_mode |=> {carry_flag, wb_data} == $past(wide));
  // R2
  a_r2_dec_carry: assert property (@(posedge clk) disable iff (rst)
    fire && dec_mode |=> carry_flag == ($past(wide) > (NIB_W+1)'(9)));
  // R3
  a_r3_zero_set: assert property (@(posedge clk) disable iff (rst)
    fire && !cmp_mode |=> zero_flag == (wb_data == '0));
  // R4
  a_r4_zero_hold: assert property (@(posedge clk) disable iff (rst)
    fire && cmp_mode |=> (wb_data == '0) ? $stable(zero_flag) : !zero_flag);
  // R8
  a_r8_stall_hold: assert property (@(posedge clk) disable iff (rst)
    wb_valid && !wb_ready |=> wb_valid && $stable(wb_data) && $stable(wb_addr)
      && $stable(wb_bank) && $stable(carry_flag) && $stable(zero_flag));
  // R8
  a_r8_no_accept: assert property (@(posedge clk) disable iff (rst)
    wb_valid && !wb_ready |-> !req_ready);
  // R9
  a_r9_reset_clear: assert property (@(posedge clk)
    rst |=> !wb_valid && !carry_flag && !zero_flag);
endmodule

bind nibadd_top nibadd_chk #(.NIB_W(NIB_W), .PTR_W(PTR_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
  .req_gr(req_gr), .req_mem(req_mem), .cmp_mode(cmp_mode),
  .wb_valid(wb_valid), .wb_ready(wb_ready), .wb_data(wb_data),
  .wb_bank(wb_bank), .wb_addr(wb_addr), .carry_flag(carry_flag),
  .zero_flag(zero_flag), .dec_mode(dec_mode)
);

// File: tb/nibadd_top_tb_top.sv
module nibadd_top_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ptr_hi_we = 0, ptr_lo_we = 0;
  logic [3:0] ptr_wdata = '0;
  logic req_valid = 0, cmp_mode = 0, wb_ready = 1;
  logic [3:0] req_gr = '0, req_mem = '0, req_ofs = '0;
  logic req_ready, wb_valid, carry_flag, zero_flag, dec_mode;
  logic [3:0] wb_data, wb_bank, gr_bank;
  logic [6:0] wb_addr, gr_addr;
  int n_chk = 0, n_bad = 0;

  always #10 clk = ~clk;

  nibadd_top dut_i (
    .clk(clk), .rst(rst), .ptr_hi_we(ptr_hi_we), .ptr_lo_we(ptr_lo_we),
    .ptr_wdata(ptr_wdata), .req_valid(req_valid), .req_ready(req_ready),
    .req_gr(req_gr), .req_mem(req_mem), .req_ofs(req_ofs), .cmp_mode(cmp_mode),
    .wb_valid(wb_valid), .wb_ready(wb_ready), .wb_data(wb_data),
    .wb_bank(wb_bank), .wb_addr(wb_addr), .carry_flag(carry_flag),
    .zero_flag(zero_flag), .gr_bank(gr_bank), .gr_addr(gr_addr), .dec_mode(dec_mode)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic set_ptr(input bit hi, input logic [3:0] v);
    @(negedge clk);
    ptr_hi_we = hi; ptr_lo_we = !hi; ptr_wdata = v;
    @(negedge clk);
    ptr_hi_we = 0; ptr_lo_we = 0;
  endtask

  // one accepted add with wb_ready high; outputs sampled at the following negedge
  task automatic do_add(input logic [3:0] a, input logic [3:0] b,
                        input logic [3:0] ofs, input bit cmp);
    @(negedge clk);
    req_valid = 1; req_gr = a; req_mem = b; req_ofs = ofs; cmp_mode = cmp;
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic t_reset;
    chk("R9 wb_valid", 16'(wb_valid), 0);
    chk("R9 carry", 16'(carry_flag), 0);
    chk("R9 zero", 16'(zero_flag), 0);
    chk("R9 bank", 16'(gr_bank), 0);
    chk("R9 mode", 16'(dec_mode), 0);
    req_ofs = 4'h3; #1;
    chk("R6 addr row0", 16'(gr_addr), 16'h03);
  endtask

  task automatic t_binary;
    do_add(4'h6, 4'h7, 4'h3, 0);
    chk("R1 sum", 16'(wb_data), 16'hD);
    chk("R1 carry0", 16'(carry_flag), 0);
    chk("R5 zero clr", 16'(zero_flag), 0);
    do_add(4'hC, 4'h9, 4'h1, 0);
    chk("R1 wrap sum", 16'(wb_data), 16'h5);
    chk("R1 carry1", 16'(carry_flag), 1);
    chk("R6 wb_addr", 16'(wb_addr), 16'h01);
  endtask

  task automatic t_zero;
    do_add(4'h8, 4'h8, 4'h0, 0);
    chk("R3 zero set", 16'(zero_flag), 1);
    chk("R1 carry", 16'(carry_flag), 1);
    do_add(4'hF, 4'h1, 4'h0, 1);
    chk("R4 zero kept 1", 16'(zero_flag), 1);
    do_add(4'h3, 4'h4, 4'h0, 1);
    chk("R5 zero clr cmp", 16'(zero_flag), 0);
    do_add(4'h0, 4'h0, 4'h0, 1);
    chk("R4 zero kept 0", 16'(zero_flag), 0);
    chk("R4 carry", 16'(carry_flag), 0);
  endtask

  task automatic t_pointer;
    set_ptr(0, 4'h4);
    req_ofs = 4'h3; #1;
    chk("R6 row2 addr", 16'(gr_addr), 16'h23);
    chk("R7 lsb binary", 16'(dec_mode), 0);
    set_ptr(1, 4'hA);
    chk("R6 bank", 16'(gr_bank), 16'hA);
    // pointer load in the same cycle as an add: old pointer used
    @(negedge clk);
    ptr_lo_we = 1; ptr_wdata = 4'h5;
    req_valid = 1; req_gr = 4'h9; req_mem = 4'h9; req_ofs = 4'hF; cmp_mode = 0;
    @(negedge clk);
    ptr_lo_we = 0; req_valid = 0;
    chk("R7 old ptr addr", 16'(wb_addr), 16'h2F);
    chk("R7 old mode bin", 16'(wb_data), 16'h2);
    chk("R6 wb_bank", 16'(wb_bank), 16'hA);
    chk("R7 new mode", 16'(dec_mode), 1);
  endtask

  task automatic t_decimal;
    do_add(4'h9, 4'h9, 4'h3, 0);
    chk("R2 9+9", 16'(wb_data), 16'h8);
    chk("R2 9+9 c", 16'(carry_flag), 1);
    chk("R6 row2 wb", 16'(wb_addr), 16'h23);
    do_add(4'h5, 4'h5, 4'h3, 0);
    chk("R2 5+5", 16'(wb_data), 16'h0);
    chk("R2 5+5 c", 16'(carry_flag), 1);
    chk("R3 dec zero", 16'(zero_flag), 1);
    do_add(4'h4, 4'h5, 4'h3, 0);
    chk("R2 4+5", 16'(wb_data), 16'h9);
    chk("R2 4+5 c", 16'(carry_flag), 0);
  endtask

  task automatic t_stall;
    set_ptr(0, 4'h0);
    @(negedge clk);
    wb_ready = 0;
    do_add(4'h2, 4'h3, 4'h4, 0);
    chk("R8 valid", 16'(wb_valid), 1);
    chk("R8 ready low", 16'(req_ready), 0);
    req_valid = 1; req_gr = 4'hF; req_mem = 4'hF; req_ofs = 4'h7; cmp_mode = 0;
    repeat (3) @(negedge clk);
    chk("R8 data held", 16'(wb_data), 16'h5);
    chk("R8 addr held", 16'(wb_addr), 16'h04);
    chk("R8 carry held", 16'(carry_flag), 0);
    wb_ready = 1;
    @(negedge clk);
    req_valid = 0;
    chk("R8 next data", 16'(wb_data), 16'hE);
    chk("R8 next carry", 16'(carry_flag), 1);
    @(negedge clk);
    chk("R8 drained", 16'(wb_valid), 0);
  endtask

  task automatic t_reset_again;
    @(negedge clk);
    rst = 1;
    @(negedge clk);
    rst = 0;
    chk("R9 carry again", 16'(carry_flag), 0);
    chk("R9 bank again", 16'(gr_bank), 0);
  endtask

  initial begin
    #4000000;
    n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    t_reset();
    t_binary();
    t_zero();
    set_ptr(1, 4'h0);
    t_pointer();
    t_decimal();
    t_stall();
    set_ptr(1, 4'h7);
    t_reset_again();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule